// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 9-bit words. A producer writes on one clock and a consumer reads on another clock that has no fixed relation to the first. The depth is a power-of-two parameter from 256 to 8192 words. Four active-low status flags report the fill level. Full and almost-full are timed by the write clock. Empty and almost-empty are timed by the read clock.

Each pointer is kept in binary on its own side and passed to the other side as a Gray code through a two-flop synchronizer. Each side therefore sees the other side's pointer a few cycles late. The flags can only err on the safe side: the write side may report more words than are stored, and the read side may report fewer.

Two offset registers set the almost thresholds. The full offset `m` places almost-full at `DEPTH-m` words. The empty offset `n` places almost-empty at `n` words or fewer. Both registers reset to 7 and are written through a load strobe on the write clock.

Top module: `pflag_fifo`

## Requirements
- R1: `full_n` goes low, on a rising `wclk` edge, when the stored word count reaches `DEPTH`. With no reads after reset, this happens after exactly `DEPTH` accepted writes.
- R2: A write attempted while `full_n` is low is dropped. It stores no data and does not change the word count.
- R3: `empty_n` is low when the buffer holds no words. A read attempted while it is low is dropped, and `rd_data` keeps its value.
- R4: A read accepted while `empty_n` is high places the oldest stored word on `rd_data` one `rclk` cycle later. Words leave in the order they were written.
- R5: Once both sides have settled, `afull_n` is low when the count is `DEPTH-m` or more, and high when the count is below that.
- R6: Once both sides have settled, `aempty_n` is low when the count is `n` or fewer (including 0), and high from `n+1` words upward.
- R7: While `rst_n` is low and after it is released, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. `rd_data` is 0, and both offsets return to 7.
- R8: A `wclk` cycle with `cfg_ld`=1 loads `cfg_val` into one offset register. `cfg_sel`=1 selects the full offset `m`, and `cfg_sel`=0 selects the empty offset `n`. The new value governs the flags once it has passed the synchronizer latency.
- R9: The pointer copies that cross between domains change by at most one bit per clock edge of their own domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full_n | output | 1 | Low when full (write clock) |
| afull_n | output | 1 | Low when almost full (write clock) |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Word read, registered |
| empty_n | output | 1 | Low when empty (read clock) |
| aempty_n | output | 1 | Low when almost empty (read clock) |
| cfg_ld | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | 1 selects the full offset, 0 selects the empty offset |
| cfg_val | input | log2(DEPTH) | Offset value to load |

## Verification
The bench checks the thresholds one word on each side of the limit, at the reset offsets and again at programmed offsets. An off-by-one compare would move a flag by one word, and a swapped select bit would move the wrong threshold. It writes into a full buffer and reads from an empty one. A design that let either request through would then show an extra word on drain, a missing empty flag or a changed `rd_data`. Random traffic with a write-heavy bias, then a read-heavy bias, drives the flags on and off while words are in transit. A pointer crossing that lost or repeated a word would break the order of the data. A second reset checks that the offsets return to 7 rather than keeping their programmed values.

// File: rtl/pff_pkg.sv
package pff_pkg;

  localparam int PTR_MAX = 14;
  localparam int DEF_OFS = 7;

  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_sel_e;

  function automatic logic [PTR_MAX-1:0] bin2gray(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] gray2bin(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/pff_rst_sync.sv
module pff_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/pff_gray_sync.sv
module pff_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pff_offsets.sv
module pff_offsets #(
  parameter int AW     = 8,
  parameter int STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          cfg_ld,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_val,
  output logic [AW-1:0] full_ofs,
  output logic [AW-1:0] empty_ofs_r
);
  import pff_pkg::*;

  localparam logic [AW-1:0] RST_OFS = AW'(DEF_OFS);

  logic [AW-1:0] m_q, m_d, n_q, n_d;
  logic          m_en, n_en;
  logic [AW-1:0] n_sync [STAGES];

  always_comb begin
    m_en = cfg_ld && (cfg_sel == OFS_FULL);
    n_en = cfg_ld && (cfg_sel == OFS_EMPTY);
    m_d  = cfg_val;
    n_d  = cfg_val;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      m_q <= RST_OFS;
      n_q <= RST_OFS;
    end else begin
      if (m_en) m_q <= m_d;
      if (n_en) n_q <= n_d;
    end
  end

  // quasi-static value: resampled into the read domain
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_nsync
      if (s == 0) begin : g_first
        always_ff @(posedge rclk or negedge rrst_n) begin
          if (!rrst_n) n_sync[s] <= RST_OFS;
          else         n_sync[s] <= n_q;
        end
      end else begin : g_next
        always_ff @(posedge rclk or negedge rrst_n) begin
          if (!rrst_n) n_sync[s] <= RST_OFS;
          else         n_sync[s] <= n_sync[s-1];
        end
      end
    end
  endgenerate

  assign full_ofs    = m_q;
  assign empty_ofs_r = n_sync[STAGES-1];
endmodule

// File: rtl/pff_wr_ctl.sv
module pff_wr_ctl #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  input  logic [AW-1:0] full_ofs,
  output logic          wr_ok,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          afull_n
);
  import pff_pkg::*;

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wbin_q, wbin_d, wgray_d, rbin_s, cnt_d;
  logic          full_n_d, afull_n_d;

  always_comb begin
    wr_ok     = wr_en && full_n;
    wbin_d    = wbin_q + PW'(wr_ok);
    wgray_d   = PW'(bin2gray(PTR_MAX'(wbin_d)));
    rbin_s    = PW'(gray2bin(PTR_MAX'(rgray_s)));
    cnt_d     = wbin_d - rbin_s;
    full_n_d  = (cnt_d != DEPTH_P);
    afull_n_d = (cnt_d < (DEPTH_P - PW'(full_ofs)));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      if (wr_ok) begin
        wbin_q <= wbin_d;
        wgray  <= wgray_d;
      end
      full_n  <= full_n_d;
      afull_n <= afull_n_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
endmodule

// File: rtl/pff_rd_ctl.sv
module pff_rd_ctl #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] empty_ofs,
  output logic          rd_ok,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty_n,
  output logic          aempty_n
);
  import pff_pkg::*;

  logic [PW-1:0] rbin_q, rbin_d, rgray_d, wbin_s, cnt_d;
  logic          empty_n_d, aempty_n_d;

  always_comb begin
    rd_ok      = rd_en && empty_n;
    rbin_d     = rbin_q + PW'(rd_ok);
    rgray_d    = PW'(bin2gray(PTR_MAX'(rbin_d)));
    wbin_s     = PW'(gray2bin(PTR_MAX'(wgray_s)));
    cnt_d      = wbin_s - rbin_d;
    empty_n_d  = (cnt_d != '0);
    aempty_n_d = (cnt_d > PW'(empty_ofs));
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      if (rd_ok) begin
        rbin_q <= rbin_d;
        rgray  <= rgray_d;
      end
      empty_n  <= empty_n_d;
      aempty_n <= aempty_n_d;
    end
  end

  assign raddr = rbin_q[AW-1:0];
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int  DEPTH       = 256,
  parameter int  WIDTH       = 9,
  parameter int  SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full_n,
  output logic             afull_n,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  output logic             aempty_n,
  input  logic             cfg_ld,
  input  logic             cfg_sel,
  input  logic [AW-1:0]    cfg_val
);
  localparam int PW = AW + 1;

  logic             wrst_n, rrst_n;
  logic             wr_ok, rd_ok;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]    full_ofs, empty_ofs_r;
  logic [WIDTH-1:0] mem [DEPTH];

  pff_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wclk), .rst_in_n(rst_n), .rst_out_n(wrst_n));
  pff_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rclk), .rst_in_n(rst_n), .rst_out_n(rrst_n));

  pff_offsets #(.AW(AW), .STAGES(SYNC_STAGES)) u_ofs (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .cfg_ld(cfg_ld), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .full_ofs(full_ofs), .empty_ofs_r(empty_ofs_r));

  pff_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .din(rgray), .dout(rgray_s));
  pff_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .din(wgray), .dout(wgray_s));

  pff_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .full_ofs(full_ofs), .wr_ok(wr_ok), .waddr(waddr), .wgray(wgray),
    .full_n(full_n), .afull_n(afull_n));

  pff_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .empty_ofs(empty_ofs_r), .rd_ok(rd_ok), .raddr(raddr), .rgray(rgray),
    .empty_n(empty_n), .aempty_n(aempty_n));

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rd_data <= '0;
    end else if (rd_ok) begin
      rd_data <= mem[raddr];
    end
  end
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
  parameter int PW    = 9,
  parameter int WIDTH = 9
) (
  input logic             wclk,
  input logic             rclk,
  input logic             wrst_n,
  input logic             rrst_n,
  input logic             full_n,
  input logic             afull_n,
  input logic             empty_n,
  input logic             aempty_n,
  input logic [WIDTH-1:0] rd_data,
  input logic [PW-1:0]    wgray,
  input logic [PW-1:0]    rgray
);
  // R2
  wr_full_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !full_n |=> $stable(wgray));

  // R3
  rd_empty_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !empty_n |=> ($stable(rgray) && $stable(rd_data)));

  // R5
  full_in_afull_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !full_n |-> !afull_n);

  // R6
  empty_in_aempty_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !empty_n |-> !aempty_n);

  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R9
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind pflag_fifo pflag_fifo_chk #(.PW(PW), .WIDTH(WIDTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .rd_data(rd_data), .wgray(wgray), .rgray(rgray));

// File: tb/test_pflag_fifo.sv
`timescale 1ns/100ps
module test_pflag_fifo;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int W     = 9;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, cfg_ld = 1'b0, cfg_sel = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] cfg_val = '0;
  logic [W-1:0]  rd_data;
  logic full_n, afull_n, empty_n, aempty_n;

  int total = 0, bad = 0, cnt = 0, m_ofs = 7, n_ofs = 7;
  logic [W-1:0] q[$];
  logic [W-1:0] next_val = '0;
  bit done = 0;

  always #4   wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  pflag_fifo #(.DEPTH(DEPTH)) i_pflag_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .full_n(full_n), .afull_n(afull_n), .rd_en(rd_en), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n), .cfg_ld(cfg_ld), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val));

  function automatic logic e_full_n(int c);          return c != DEPTH;      endfunction
  function automatic logic e_afull_n(int c, int m);  return c < (DEPTH - m); endfunction
  function automatic logic e_empty_n(int c);         return c != 0;          endfunction
  function automatic logic e_aempty_n(int c, int n); return c > n;           endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic check_flags(string req);
    settle();
    chk(full_n == e_full_n(cnt), req, "full_n", int'(full_n), int'(e_full_n(cnt)));
    chk(afull_n == e_afull_n(cnt, m_ofs), req, "afull_n", int'(afull_n),
        int'(e_afull_n(cnt, m_ofs)));
    chk(empty_n == e_empty_n(cnt), req, "empty_n", int'(empty_n), int'(e_empty_n(cnt)));
    chk(aempty_n == e_aempty_n(cnt, n_ofs), req, "aempty_n", int'(aempty_n),
        int'(e_aempty_n(cnt, n_ofs)));
  endtask

  task automatic wr_n(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge wclk);
      wr_en   = 1'b1;
      wr_data = next_val;
      if (cnt < DEPTH) begin
        q.push_back(next_val);
        cnt++;
      end
      next_val = next_val + 9'd1;
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd_n(int k);
    bit pend = 0;
    logic [W-1:0] exp = '0;
    for (int i = 0; i < k; i++) begin
      @(negedge rclk);
      if (pend) chk(rd_data == exp, "R4", "rd_data", int'(rd_data), int'(exp));
      rd_en = 1'b1;
      if (cnt > 0) begin
        pend = 1;
        exp  = q.pop_front();
        cnt--;
      end else begin
        pend = 0;
      end
    end
    @(negedge rclk);
    rd_en = 1'b0;
    if (pend) chk(rd_data == exp, "R4", "rd_data", int'(rd_data), int'(exp));
  endtask

  task automatic load_ofs(bit sel, int val);
    @(negedge wclk);
    cfg_ld  = 1'b1;
    cfg_sel = sel;
    cfg_val = AW'(val);
    @(negedge wclk);
    cfg_ld  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 1'b0;
    repeat (4) @(negedge rclk);
    chk(empty_n == 1'b0 && aempty_n == 1'b0, "R7", "read flags in reset",
        int'({empty_n, aempty_n}), 0);
    chk(full_n == 1'b1 && afull_n == 1'b1, "R7", "write flags in reset",
        int'({full_n, afull_n}), 3);
    @(negedge wclk);
    rst_n = 1'b1;
    q.delete();
    cnt = 0; m_ofs = 7; n_ofs = 7;
    settle();
    chk(rd_data == '0, "R7", "rd_data after reset", int'(rd_data), 0);
  endtask

  task automatic rand_phase(int wp, int rp);
    fork
      begin
        for (int i = 0; i < 1200; i++) begin
          @(negedge wclk);
          wr_en   = ($urandom % 100) < wp;
          wr_data = W'($urandom);
          if (wr_en && full_n) q.push_back(wr_data);
        end
        @(negedge wclk);
        wr_en = 1'b0;
      end
      begin
        bit pend = 0;
        logic [W-1:0] exp = '0;
        for (int i = 0; i < 873; i++) begin
          @(negedge rclk);
          if (pend) chk(rd_data == exp, "R4", "random rd_data", int'(rd_data), int'(exp));
          pend  = 0;
          rd_en = ($urandom % 100) < rp;
          if (rd_en && empty_n) begin
            if (q.size() == 0) begin
              chk(0, "R3", "read accepted with nothing stored", 1, 0);
            end else begin
              exp  = q.pop_front();
              pend = 1;
            end
          end
        end
        @(negedge rclk);
        rd_en = 1'b0;
        if (pend) chk(rd_data == exp, "R4", "random rd_data", int'(rd_data), int'(exp));
      end
    join
    cnt = q.size();
  endtask

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd5813));
    do_reset();
    check_flags("R7");

    // R3: read of an empty buffer is dropped
    held = rd_data;
    rd_n(3);
    chk(rd_data == held, "R3", "rd_data on empty read", int'(rd_data), int'(held));
    check_flags("R3");

    // R6 with default offset 7
    wr_n(7);   check_flags("R6");
    wr_n(1);   check_flags("R6");
    // R5 with default offset 7
    wr_n(240); check_flags("R5");
    wr_n(1);   check_flags("R5");
    // R1: full at exactly DEPTH words
    wr_n(6);   check_flags("R1");
    wr_n(1);   check_flags("R1");
    // R2: writes into a full buffer are dropped
    wr_n(5);   check_flags("R2");
    rd_n(DEPTH);
    check_flags("R2");

    // R8: programmed offsets m=20, n=3
    load_ofs(1'b1, 20); m_ofs = 20;
    load_ofs(1'b0, 3);  n_ofs = 3;
    check_flags("R8");
    wr_n(3);   check_flags("R6");
    wr_n(1);   check_flags("R6");
    wr_n(231); check_flags("R5");
    wr_n(1);   check_flags("R8");
    rd_n(cnt); check_flags("R3");

    // random traffic with varying bias
    rand_phase(75, 25);
    rand_phase(25, 75);
    rand_phase(50, 50);
    rd_n(cnt);
    check_flags("R4");

    // R7: reset restores offset 7
    do_reset();
    wr_n(7);   check_flags("R7");
    wr_n(1);   check_flags("R7");
    rd_n(cnt); check_flags("R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule